// File: doc/BRIEF.md
# Per-Packet Receive Error Counter

This block keeps a statistics count of received packets that carried at least one receive error. It watches three signals in the receive clock domain: a packet window (`rx_valid`), a per-cycle error strobe (`rx_err`) and a collision indicator (`rx_col`). The block keeps a small per-packet record of whether an error or a collision was seen. When the window closes, the count advances by one if an error was seen and no collision was seen.

A management port gives software access to the count. `mg_rdata` always shows the live count. A read strobe clears the count at the same clock edge, so each read returns the errors gathered since the last read. A write strobe loads any value into the count. The count wraps at its full-scale value instead of holding there. A parameter selects between clear-on-read and plain read.

Top module: `rxerr_pkt_counter`

## Requirements
- R1: During and after reset the count is 0 and `mg_rdata` reads 0.
- R2: A packet with any number of cycles where `rx_err` is high adds exactly 1 to the count.
- R3: The count changes only at the first clock edge at which `rx_valid` is sampled low after being high. It never changes while `rx_valid` is high, unless a management access causes the change.
- R4: A packet with `rx_col` high in any of its valid cycles is not counted, whatever the errors.
- R5: The count wraps from all ones (0xFFFF at the default width) to 0.
- R6: `mg_rdata` shows the current count in the same cycle. With clear-on-read selected, a clock edge with `mg_rd` high leaves the count at 0.
- R7: If a read-clear and an end-of-packet increment fall on the same edge, the count becomes 1.
- R8: A clock edge with `mg_wr` high loads `mg_wdata` into the count. A write wins over a simultaneous read or increment.
- R9: `rx_err` and `rx_col` have no effect while `rx_valid` is low. The per-packet error and collision record restarts at the first valid cycle of every packet.
- R10: A packet with no error cycles leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | High for every cycle of a received packet |
| rx_err | input | 1 | Receive error seen this cycle |
| rx_col | input | 1 | Collision seen this cycle |
| mg_rd | input | 1 | Management read strobe (clears the count on read) |
| mg_wr | input | 1 | Management write strobe |
| mg_wdata | input | CNT_W | Value to load on write |
| mg_rdata | output | CNT_W | Live count value |

## Verification
The bench builds the block with the default 16-bit width and clear-on-read selected. It preloads the count through the write port to reach the 0xFFFF wrap, which packets alone would take tens of thousands of runs to reach. It also lines up read and write strobes with the cycle after a packet ends, which tests the same-edge priority rules. Random packets of varied length mix errors, collisions and management accesses with idle gaps of one cycle or more, so back-to-back packet restarts are tested as well.

// File: rtl/rxerr_cnt_pkg.sv
package rxerr_cnt_pkg;

   typedef enum logic [2:0] {
      ACT_HOLD       = 3'd0,
      ACT_BUMP       = 3'd1,
      ACT_CLEAR      = 3'd2,
      ACT_CLEAR_BUMP = 3'd3,
      ACT_LOAD       = 3'd4
   } cnt_act_t;

   typedef struct packed {
      logic err_seen;
      logic col_seen;
   } pkt_rec_t;

   function automatic pkt_rec_t rec_merge(pkt_rec_t cur, logic start,
                                          logic err, logic col);
      pkt_rec_t nxt;
      if (start) begin
         nxt.err_seen = err;
         nxt.col_seen = col;
      end else begin
         nxt.err_seen = cur.err_seen | err;
         nxt.col_seen = cur.col_seen | col;
      end
      return nxt;
   endfunction

endpackage

// File: rtl/rxerr_pkt_track.sv
module rxerr_pkt_track
   import rxerr_cnt_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic rx_valid,
   input  logic rx_err,
   input  logic rx_col,
   output logic pkt_bump
);

   logic     valid_q;
   pkt_rec_t rec_q;
   pkt_rec_t rec_d;
   logic     pkt_start;
   logic     pkt_end;

   assign pkt_start = rx_valid & ~valid_q;
   assign pkt_end   = valid_q & ~rx_valid;

   always_comb begin
      rec_d = rec_q;
      if (rx_valid) begin
         rec_d = rec_merge(rec_q, pkt_start, rx_err, rx_col);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         rec_q   <= '0;
      end else begin
         valid_q <= rx_valid;
         rec_q   <= rec_d;
      end
   end

   assign pkt_bump = pkt_end & rec_q.err_seen & ~rec_q.col_seen;

endmodule

// File: rtl/rxerr_mgmt_arb.sv
module rxerr_mgmt_arb
   import rxerr_cnt_pkg::*;
#(
   parameter bit RD_CLEAR = 1'b1
) (
   input  logic     mg_rd,
   input  logic     mg_wr,
   input  logic     bump,
   output cnt_act_t act
);

   generate
      if (RD_CLEAR) begin : g_rd_clear
         always_comb begin
            if (mg_wr)               act = ACT_LOAD;
            else if (mg_rd && bump)  act = ACT_CLEAR_BUMP;
            else if (mg_rd)          act = ACT_CLEAR;
            else if (bump)           act = ACT_BUMP;
            else                     act = ACT_HOLD;
         end
      end else begin : g_rd_plain
         logic unused_rd;
         assign unused_rd = mg_rd;
         always_comb begin
            if (mg_wr)      act = ACT_LOAD;
            else if (bump)  act = ACT_BUMP;
            else            act = ACT_HOLD;
         end
      end
   endgenerate

endmodule

// File: rtl/rxerr_cnt_core.sv
module rxerr_cnt_core
   import rxerr_cnt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cnt_act_t         act,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;

   always_comb begin
      unique case (act)
         ACT_BUMP:       cnt_d = cnt_q + ONE;
         ACT_CLEAR:      cnt_d = '0;
         ACT_CLEAR_BUMP: cnt_d = ONE;
         ACT_LOAD:       cnt_d = load_val;
         default:        cnt_d = cnt_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign count = cnt_q;

endmodule

// File: rtl/rxerr_pkt_counter.sv
module rxerr_pkt_counter
   import rxerr_cnt_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter bit RD_CLEAR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_valid,
   input  logic             rx_err,
   input  logic             rx_col,
   input  logic             mg_rd,
   input  logic             mg_wr,
   input  logic [CNT_W-1:0] mg_wdata,
   output logic [CNT_W-1:0] mg_rdata
);

   generate
      if (CNT_W < 2 || CNT_W > 64) begin : g_bad_width
         $error("rxerr_pkt_counter: CNT_W must lie in 2..64");
      end
   endgenerate

   logic     bump;
   cnt_act_t act;

   rxerr_pkt_track u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_valid (rx_valid),
      .rx_err   (rx_err),
      .rx_col   (rx_col),
      .pkt_bump (bump)
   );

   rxerr_mgmt_arb #(.RD_CLEAR(RD_CLEAR)) u_arb (
      .mg_rd (mg_rd),
      .mg_wr (mg_wr),
      .bump  (bump),
      .act   (act)
   );

   rxerr_cnt_core #(.CNT_W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .act      (act),
      .load_val (mg_wdata),
      .count    (mg_rdata)
   );

endmodule

// File: rtl/rxerr_pkt_counter_chk.sv
module rxerr_pkt_counter_chk #(
   parameter int CNT_W    = 16,
   parameter bit RD_CLEAR = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_valid,
   input logic             mg_rd,
   input logic             mg_wr,
   input logic [CNT_W-1:0] mg_wdata,
   input logic [CNT_W-1:0] mg_rdata
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   // R2: without management access the count steps by at most one
   p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!mg_rd && !mg_wr) |=>
         (mg_rdata == $past(mg_rdata) || mg_rdata == $past(mg_rdata) + ONE));

   // R3: no change while the packet window is still open
   p_hold_in_pkt_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !mg_rd && !mg_wr) |=> $stable(mg_rdata));

   // R5: full scale either holds or wraps to zero
   p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mg_rdata == '1 && !mg_rd && !mg_wr) |=> (mg_rdata == '1 || mg_rdata == '0));

   // R8: a write always lands
   p_write_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mg_wr |=> mg_rdata == $past(mg_wdata));

   generate
      if (RD_CLEAR) begin : g_rd_chk
         // R6 / R7: after a read the count is 0, or 1 if a packet closed on that edge
         p_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (mg_rd && !mg_wr) |=> (mg_rdata == '0 || mg_rdata == ONE));
      end
   endgenerate

endmodule

bind rxerr_pkt_counter rxerr_pkt_counter_chk #(.CNT_W(CNT_W), .RD_CLEAR(RD_CLEAR)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rx_valid (rx_valid),
   .mg_rd    (mg_rd),
   .mg_wr    (mg_wr),
   .mg_wdata (mg_wdata),
   .mg_rdata (mg_rdata)
);

// File: tb/rxerr_pkt_counter_tb_top.sv
module rxerr_pkt_counter_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 16;
   localparam int WATCHDOG   = 100000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             rx_valid = 1'b0;
   logic             rx_err = 1'b0;
   logic             rx_col = 1'b0;
   logic             mg_rd = 1'b0;
   logic             mg_wr = 1'b0;
   logic [CNT_W-1:0] mg_wdata = '0;
   logic [CNT_W-1:0] mg_rdata;

   int  n_checks = 0;
   int  n_errors = 0;
   int  n_cycles = 0;
   bit  done = 1'b0;

   // reference state, built from the requirements
   bit               m_vq = 1'b0;
   bit               m_err = 1'b0;
   bit               m_col = 1'b0;
   logic [CNT_W-1:0] m_cnt = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rxerr_pkt_counter #(.CNT_W(CNT_W), .RD_CLEAR(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_err(rx_err),
      .rx_col(rx_col), .mg_rd(mg_rd), .mg_wr(mg_wr),
      .mg_wdata(mg_wdata), .mg_rdata(mg_rdata)
   );

   function automatic logic [CNT_W-1:0] exp_next(bit v, bit rd, bit wr,
                                                 logic [CNT_W-1:0] wd);
      bit bump;
      bump = m_vq && !v && m_err && !m_col;
      if (wr)      return wd;
      else if (rd) return bump ? CNT_W'(1) : '0;
      else         return m_cnt + (bump ? CNT_W'(1) : '0);
   endfunction

   task automatic check(string req, logic [CNT_W-1:0] act, logic [CNT_W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one cycle: drive at negedge, check the live read, clock, check the result
   task automatic step(string req, bit v, bit e, bit c, bit rd = 0, bit wr = 0,
                       logic [CNT_W-1:0] wd = '0);
      logic [CNT_W-1:0] exp;
      rx_valid = v; rx_err = e; rx_col = c; mg_rd = rd; mg_wr = wr; mg_wdata = wd;
      #1;
      if (rd) check("R6 live read", mg_rdata, m_cnt);
      exp = exp_next(v, rd, wr, wd);
      if (v) begin
         if (!m_vq) begin m_err = e; m_col = c; end
         else begin m_err |= e; m_col |= c; end
      end
      m_vq = v;
      m_cnt = exp;
      @(posedge clk);
      @(negedge clk);
      check(req, mg_rdata, exp);
   endtask

   task automatic idle(string req, int n);
      for (int i = 0; i < n; i++) step(req, 0, 0, 0);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         n_cycles++;
         if (n_cycles > WATCHDOG && !done) begin
            done = 1'b1;
            n_errors++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", n_cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
         end
      end
   end

   initial begin
      void'($urandom(32'h1234_abcd));
      @(negedge clk);
      check("R1 in reset", mg_rdata, '0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", mg_rdata, '0);

      // R2: three error cycles, one increment; R3: stable mid-packet
      step("R3 mid", 1, 1, 0);
      step("R3 mid", 1, 0, 0);
      step("R3 mid", 1, 1, 0);
      step("R2 last", 1, 1, 0);
      step("R2 end", 0, 0, 0);
      check("R2 count one", mg_rdata, 16'h0001);

      // R10: clean packet
      step("R10", 1, 0, 0); step("R10", 1, 0, 0); step("R10 end", 0, 0, 0);
      check("R10 unchanged", mg_rdata, 16'h0001);

      // R4: collision then error
      step("R4", 1, 0, 1); step("R4", 1, 1, 0); step("R4 end", 0, 0, 0);
      check("R4 no count", mg_rdata, 16'h0001);

      // R9: errors and collisions when idle ignored; record restarts per packet
      step("R9 idle err", 0, 1, 1); step("R9 idle err", 0, 1, 0);
      step("R9", 1, 0, 0); step("R9 end", 0, 0, 0);
      check("R9 idle ignored", mg_rdata, 16'h0001);
      step("R9 col pkt", 1, 0, 1); step("R9 end", 0, 0, 0);
      step("R9 err pkt", 1, 1, 0); step("R9 end", 0, 0, 0);
      check("R9 restart", mg_rdata, 16'h0002);

      // R6: read clears
      step("R6 clear", 0, 0, 0, 1);
      check("R6 cleared", mg_rdata, 16'h0000);

      // R7: read on the end-of-packet edge
      step("R7", 1, 1, 0); step("R7 end+read", 0, 0, 0, 1);
      check("R7 one", mg_rdata, 16'h0001);

      // R5 and R8: preload full scale, then wrap
      step("R8 load", 0, 0, 0, 0, 1, 16'hFFFF);
      check("R8 loaded", mg_rdata, 16'hFFFF);
      step("R5", 1, 1, 0); step("R5 end", 0, 0, 0);
      check("R5 wrap", mg_rdata, 16'h0000);

      // R8: write beats read and increment on the same edge
      step("R8", 1, 1, 0); step("R8 wr+rd+eop", 0, 0, 0, 1, 1, 16'h00A5);
      check("R8 priority", mg_rdata, 16'h00A5);

      // random packets
      for (int p = 0; p < 400; p++) begin
         int len;
         int gap;
         len = 1 + int'($urandom_range(7));
         gap = 1 + int'($urandom_range(2));
         for (int k = 0; k < len; k++)
            step("R2 rand", 1, ($urandom_range(7) == 0), ($urandom_range(15) == 0),
                 ($urandom_range(15) == 0), ($urandom_range(31) == 0),
                 CNT_W'($urandom));
         for (int k = 0; k < gap; k++)
            step("R3 rand", 0, ($urandom_range(3) == 0), ($urandom_range(3) == 0),
                 ($urandom_range(7) == 0), ($urandom_range(31) == 0),
                 CNT_W'($urandom));
      end

      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end

endmodule